// File: doc/BRIEF.md
# NTSC/PAL Raster Timing Generator

This block produces all the raster timing a composite video encoder needs. One pixel-rate clock enable drives it. It counts pixels, lines and fields for the selected television standard. From those counts it derives the following outputs, all registered:

- an active-low horizontal sync (`hs_n`)
- an active-low vertical sync (`vs_n`)
- a composite blanking flag (`blank`)
- a colour burst gate (`burst`)
- a one-cycle strobe on the first visible pixel of each line (`act_start`)
- the current line and field numbers

There are four standards: interlaced NTSC (525 lines, 4-field sequence), interlaced PAL (625 lines, 8-field sequence), and a progressive variant of each. A progressive variant repeats one whole-line field of 263 or 313 lines.

A separate timing reset holds the raster at its starting point and leaves anything downstream untouched. It is also the only moment at which a new standard is taken from the `mode` input. The first enabled clock after the timing reset is released emits pixel 0 of line 1 of field 1.

Horizontal quantities are parameters: line length, sync width, the offset from the end of sync to the first visible pixel, and the burst window. Their defaults are the real pixel counts. The line and half-line blanking maps are fixed by the standards.

Top module: `vt_raster_gen`

## Requirements
- R1: After the synchronous reset every output is idle: `hs_n`=1, `vs_n`=1, `blank`=1, `burst`=0, `act_start`=0, `line_num`=0, `field_num`=0. The active standard is NTSC (code 00) whatever the `mode` input holds. The first enabled clock after reset emits line 1, field 1.
- R2: `mode` encodes 00 = NTSC interlaced, 01 = NTSC progressive, 10 = PAL interlaced, 11 = PAL progressive. It is taken only on enabled clocks while `tim_rst` is high; a change at any other time has no effect.
- R3: `line_num` counts 1..525 (NTSC) or 1..625 (PAL) over the frame. `field_num` steps 1,2,3,4 (NTSC) or 1..8 (PAL) and then returns to 1. Odd fields begin at pixel 0 of line 1. Even fields begin at the half-line pixel of line 263 (NTSC) or line 313 (PAL).
- R4: In the progressive standards `line_num` counts 1..263 (NTSC) or 1..313 (PAL) and `field_num` stays at 1.
- R5: `hs_n` is low for the first HS-width pixels of every line, including lines inside the vertical sync interval. The default widths are 59 pixels (NTSC) and 69 pixels (PAL).
- R6: `vs_n` is low for the first 3 lines of each NTSC field and the first 2.5 lines of each PAL field, measured from the field start.
- R7: `hs_n` and `vs_n` fall on the same clock exactly when an odd field begins, that is at line 1, pixel 0.
- R8: In NTSC, `blank` is high on lines 1–17, 261–279 and 523–525, on the second half of line 260, and on the first half of line 280.
- R9: In PAL, `blank` is high on lines 1–22, 311–335 and 624–625, on the second half of line 623, and on the first half of line 23.
- R10: On every line, `blank` is high until the active offset after the rising edge of `hs_n`. The defaults are 48 pixels (NTSC) and 58 pixels (PAL). `act_start` pulses for one pixel on the first pixel where `blank` falls within a line.
- R11: `burst` is high for a fixed window that starts a fixed delay after `hs_n` rises. It appears only on lines whose first pixel is not vertically blanked.
- R12: While `tim_rst` is high on enabled clocks the outputs are idle, as in R1. On the first enabled clock after it falls, line 1 of field 1 begins at pixel 0.
- R13: On a clock where `pix_en` is low no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate clock enable |
| tim_rst | input | 1 | Timing reset: holds the raster at its start and loads `mode` |
| mode | input | 2 | Standard select (see R2) |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| blank | output | 1 | Composite blanking flag |
| burst | output | 1 | Colour burst gate |
| act_start | output | 1 | Strobe on the first visible pixel of a line |
| line_num | output | 10 | Current line, 1-based; 0 when idle |
| field_num | output | 4 | Current field, 1-based; 0 when idle |

## Verification
The hardest situations to reach from the ports lie deep in a long raster:
- the return from PAL field 8 to field 1 after 2500 lines;
- the even-field vertical sync that starts in the middle of line 263 or 313;
- the half-blanked lines next to the even-field blanking interval.

The bench shrinks the line lengths and horizontal offsets through parameters so that complete multi-frame sequences fit. It then sweeps every pixel of every line in all four standards against a model of the blanking maps built from line numbers. Clock-enable stalls are mixed into the NTSC run. A timing reset in mid-frame, with a new `mode` value held during it, exercises the restart and the point at which the standard is taken.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [1:0] {
    STD_NTSC      = 2'b00,
    STD_NTSC_PROG = 2'b01,
    STD_PAL       = 2'b10,
    STD_PAL_PROG  = 2'b11
  } std_mode_e;

  localparam int LINE_W  = 10;
  localparam int FIELD_W = 4;
  localparam int HALF_W  = LINE_W + 1;

  // Frame geometry in lines
  localparam int NTSC_FRAME_LINES = 525;
  localparam int PAL_FRAME_LINES  = 625;
  localparam int NTSC_PROG_LINES  = 263;
  localparam int PAL_PROG_LINES   = 313;
  localparam int NTSC_FIELDS      = 4;
  localparam int PAL_FIELDS       = 8;

  // Vertical sync length in half lines
  localparam int NTSC_VS_HALVES = 6;
  localparam int PAL_VS_HALVES  = 5;

  // Vertical blanking windows, half-line index h = 2*(line-1) + second_half,
  // each window is [begin, end)
  localparam int NTSC_VB0_END = 34;
  localparam int NTSC_VB1_BEG = 519;
  localparam int NTSC_VB1_END = 559;
  localparam int NTSC_VB2_BEG = 1044;
  localparam int NTSC_VB2_END = 1050;
  localparam int PAL_VB0_END  = 45;
  localparam int PAL_VB1_BEG  = 620;
  localparam int PAL_VB1_END  = 670;
  localparam int PAL_VB2_BEG  = 1245;
  localparam int PAL_VB2_END  = 1250;

  typedef struct packed {
    logic               interlaced;
    logic [LINE_W-1:0]  last_line;
    logic [LINE_W-1:0]  mid_line;
    logic [FIELD_W-1:0] last_field;
    logic [HALF_W-1:0]  vs_halves;
    logic [HALF_W-1:0]  vb0_end;
    logic [HALF_W-1:0]  vb1_beg;
    logic [HALF_W-1:0]  vb1_end;
    logic [HALF_W-1:0]  vb2_beg;
    logic [HALF_W-1:0]  vb2_end;
  } line_cfg_t;

  function automatic logic in_vblank(input line_cfg_t c, input logic [HALF_W-1:0] h);
    return (h < c.vb0_end) ||
           ((h >= c.vb1_beg) && (h < c.vb1_end)) ||
           ((h >= c.vb2_beg) && (h < c.vb2_end));
  endfunction

endpackage

// File: rtl/vt_mode_cfg.sv
module vt_mode_cfg
  import vt_pkg::*;
#(
  parameter int PIX_W         = 10,
  parameter int NTSC_LINE_PIX = 796,
  parameter int NTSC_HS_PIX   = 59,
  parameter int NTSC_ACT_OFS  = 48,
  parameter int PAL_LINE_PIX  = 944,
  parameter int PAL_HS_PIX    = 69,
  parameter int PAL_ACT_OFS   = 58,
  parameter int BURST_OFS     = 5,
  parameter int BURST_PIX     = 35
) (
  input  std_mode_e        mode,
  output line_cfg_t        lcfg,
  output logic [PIX_W-1:0] last_pix,
  output logic [PIX_W-1:0] half_pix,
  output logic [PIX_W-1:0] hs_pix,
  output logic [PIX_W-1:0] act_pix,
  output logic [PIX_W-1:0] burst_beg,
  output logic [PIX_W-1:0] burst_end
);

  localparam logic [PIX_W-1:0] N_LAST  = PIX_W'(NTSC_LINE_PIX - 1);
  localparam logic [PIX_W-1:0] N_HALF  = PIX_W'(NTSC_LINE_PIX / 2);
  localparam logic [PIX_W-1:0] N_HS    = PIX_W'(NTSC_HS_PIX);
  localparam logic [PIX_W-1:0] N_ACT   = PIX_W'(NTSC_HS_PIX + NTSC_ACT_OFS);
  localparam logic [PIX_W-1:0] N_BBEG  = PIX_W'(NTSC_HS_PIX + BURST_OFS);
  localparam logic [PIX_W-1:0] N_BEND  = PIX_W'(NTSC_HS_PIX + BURST_OFS + BURST_PIX);
  localparam logic [PIX_W-1:0] P_LAST  = PIX_W'(PAL_LINE_PIX - 1);
  localparam logic [PIX_W-1:0] P_HALF  = PIX_W'(PAL_LINE_PIX / 2);
  localparam logic [PIX_W-1:0] P_HS    = PIX_W'(PAL_HS_PIX);
  localparam logic [PIX_W-1:0] P_ACT   = PIX_W'(PAL_HS_PIX + PAL_ACT_OFS);
  localparam logic [PIX_W-1:0] P_BBEG  = PIX_W'(PAL_HS_PIX + BURST_OFS);
  localparam logic [PIX_W-1:0] P_BEND  = PIX_W'(PAL_HS_PIX + BURST_OFS + BURST_PIX);

  logic is_pal;
  logic is_prog;

  always_comb begin
    is_pal  = (mode == STD_PAL) || (mode == STD_PAL_PROG);
    is_prog = (mode == STD_NTSC_PROG) || (mode == STD_PAL_PROG);

    lcfg.interlaced = !is_prog;
    if (is_pal) begin
      lcfg.last_line  = is_prog ? LINE_W'(PAL_PROG_LINES) : LINE_W'(PAL_FRAME_LINES);
      lcfg.mid_line   = LINE_W'(PAL_PROG_LINES);
      lcfg.last_field = is_prog ? FIELD_W'(1) : FIELD_W'(PAL_FIELDS);
      lcfg.vs_halves  = HALF_W'(PAL_VS_HALVES);
      lcfg.vb0_end    = HALF_W'(PAL_VB0_END);
      lcfg.vb1_beg    = HALF_W'(PAL_VB1_BEG);
      lcfg.vb1_end    = HALF_W'(PAL_VB1_END);
      lcfg.vb2_beg    = HALF_W'(PAL_VB2_BEG);
      lcfg.vb2_end    = HALF_W'(PAL_VB2_END);
      last_pix        = P_LAST;
      half_pix        = P_HALF;
      hs_pix          = P_HS;
      act_pix         = P_ACT;
      burst_beg       = P_BBEG;
      burst_end       = P_BEND;
    end else begin
      lcfg.last_line  = is_prog ? LINE_W'(NTSC_PROG_LINES) : LINE_W'(NTSC_FRAME_LINES);
      lcfg.mid_line   = LINE_W'(NTSC_PROG_LINES);
      lcfg.last_field = is_prog ? FIELD_W'(1) : FIELD_W'(NTSC_FIELDS);
      lcfg.vs_halves  = HALF_W'(NTSC_VS_HALVES);
      lcfg.vb0_end    = HALF_W'(NTSC_VB0_END);
      lcfg.vb1_beg    = HALF_W'(NTSC_VB1_BEG);
      lcfg.vb1_end    = HALF_W'(NTSC_VB1_END);
      lcfg.vb2_beg    = HALF_W'(NTSC_VB2_BEG);
      lcfg.vb2_end    = HALF_W'(NTSC_VB2_END);
      last_pix        = N_LAST;
      half_pix        = N_HALF;
      hs_pix          = N_HS;
      act_pix         = N_ACT;
      burst_beg       = N_BBEG;
      burst_end       = N_BEND;
    end
  end

endmodule

// File: rtl/vt_raster_cnt.sv
module vt_raster_cnt
  import vt_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               tim_rst,
  input  line_cfg_t          lcfg,
  input  logic [PIX_W-1:0]   last_pix,
  input  logic [PIX_W-1:0]   half_pix,
  output logic [PIX_W-1:0]   pix,
  output logic [LINE_W-1:0]  line,
  output logic [FIELD_W-1:0] field
);

  // The counters hold the position the decoder emits on the next enabled clock.
  logic end_of_line;
  logic end_of_frame;
  logic to_second_field;
  logic to_next_field;

  always_comb begin
    end_of_line     = (pix == last_pix);
    end_of_frame    = end_of_line && (line == lcfg.last_line);
    to_second_field = (line == lcfg.mid_line) && (pix == half_pix - 1'b1);
    to_next_field   = lcfg.interlaced && (end_of_frame || to_second_field);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix   <= '0;
      line  <= LINE_W'(1);
      field <= FIELD_W'(1);
    end else if (pix_en) begin
      if (tim_rst) begin
        pix   <= '0;
        line  <= LINE_W'(1);
        field <= FIELD_W'(1);
      end else begin
        pix <= end_of_line ? '0 : pix + 1'b1;
        if (end_of_line) begin
          line <= end_of_frame ? LINE_W'(1) : line + 1'b1;
        end
        if (to_next_field) begin
          field <= (field == lcfg.last_field) ? FIELD_W'(1) : field + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vt_sync_decode.sv
module vt_sync_decode
  import vt_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               tim_rst,
  input  line_cfg_t          lcfg,
  input  logic [PIX_W-1:0]   half_pix,
  input  logic [PIX_W-1:0]   hs_pix,
  input  logic [PIX_W-1:0]   act_pix,
  input  logic [PIX_W-1:0]   burst_beg,
  input  logic [PIX_W-1:0]   burst_end,
  input  logic [PIX_W-1:0]   pix,
  input  logic [LINE_W-1:0]  line,
  input  logic [FIELD_W-1:0] field,
  output logic               hs_n,
  output logic               vs_n,
  output logic               blank,
  output logic               burst,
  output logic               act_start,
  output logic [LINE_W-1:0]  line_num,
  output logic [FIELD_W-1:0] field_num
);

  logic [LINE_W-1:0] line_idx;
  logic [HALF_W-1:0] h_now;
  logic [HALF_W-1:0] h_start;
  logic [HALF_W-1:0] f2_start;
  logic              vb_now;
  logic              vb_start;
  logic              hs_low;
  logic              vs_low;
  logic              blank_d;
  logic              burst_d;
  logic              act_d;

  always_comb begin
    line_idx = line - 1'b1;
    h_now    = {line_idx, (pix >= half_pix)};
    h_start  = {line_idx, 1'b0};
    f2_start = {lcfg.mid_line - 1'b1, 1'b1};
    vb_now   = in_vblank(lcfg, h_now);
    vb_start = in_vblank(lcfg, h_start);
    hs_low   = (pix < hs_pix);
    vs_low   = (h_now < lcfg.vs_halves) ||
               (lcfg.interlaced && (h_now >= f2_start) &&
                (h_now < f2_start + lcfg.vs_halves));
    blank_d  = vb_now || (pix < act_pix);
    burst_d  = !vb_start && (pix >= burst_beg) && (pix < burst_end);
    act_d    = !blank_d && ((pix == act_pix) || ((pix == half_pix) && vb_start));
  end

  always_ff @(posedge clk) begin
    if (rst || (pix_en && tim_rst)) begin
      hs_n      <= 1'b1;
      vs_n      <= 1'b1;
      blank     <= 1'b1;
      burst     <= 1'b0;
      act_start <= 1'b0;
      line_num  <= '0;
      field_num <= '0;
    end else if (pix_en) begin
      hs_n      <= !hs_low;
      vs_n      <= !vs_low;
      blank     <= blank_d;
      burst     <= burst_d;
      act_start <= act_d;
      line_num  <= line;
      field_num <= field;
    end
  end

endmodule

// File: rtl/vt_raster_gen.sv
module vt_raster_gen
  import vt_pkg::*;
#(
  parameter int NTSC_LINE_PIX = 796,
  parameter int NTSC_HS_PIX   = 59,
  parameter int NTSC_ACT_OFS  = 48,
  parameter int PAL_LINE_PIX  = 944,
  parameter int PAL_HS_PIX    = 69,
  parameter int PAL_ACT_OFS   = 58,
  parameter int BURST_OFS     = 5,
  parameter int BURST_PIX     = 35
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               tim_rst,
  input  logic [1:0]         mode,
  output logic               hs_n,
  output logic               vs_n,
  output logic               blank,
  output logic               burst,
  output logic               act_start,
  output logic [LINE_W-1:0]  line_num,
  output logic [FIELD_W-1:0] field_num
);

  localparam int MAX_LINE_PIX = (NTSC_LINE_PIX > PAL_LINE_PIX) ? NTSC_LINE_PIX : PAL_LINE_PIX;
  localparam int PIX_W        = $clog2(MAX_LINE_PIX + 1);

  std_mode_e         mode_q;
  line_cfg_t         lcfg;
  logic [PIX_W-1:0]  last_pix;
  logic [PIX_W-1:0]  half_pix;
  logic [PIX_W-1:0]  hs_pix;
  logic [PIX_W-1:0]  act_pix;
  logic [PIX_W-1:0]  burst_beg;
  logic [PIX_W-1:0]  burst_end;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic [FIELD_W-1:0] field;

  // Standard is taken only while the raster is held by the timing reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= STD_NTSC;
    end else if (pix_en && tim_rst) begin
      mode_q <= std_mode_e'(mode);
    end
  end

  vt_mode_cfg #(
    .PIX_W         (PIX_W),
    .NTSC_LINE_PIX (NTSC_LINE_PIX),
    .NTSC_HS_PIX   (NTSC_HS_PIX),
    .NTSC_ACT_OFS  (NTSC_ACT_OFS),
    .PAL_LINE_PIX  (PAL_LINE_PIX),
    .PAL_HS_PIX    (PAL_HS_PIX),
    .PAL_ACT_OFS   (PAL_ACT_OFS),
    .BURST_OFS     (BURST_OFS),
    .BURST_PIX     (BURST_PIX)
  ) i_cfg (
    .mode      (mode_q),
    .lcfg      (lcfg),
    .last_pix  (last_pix),
    .half_pix  (half_pix),
    .hs_pix    (hs_pix),
    .act_pix   (act_pix),
    .burst_beg (burst_beg),
    .burst_end (burst_end)
  );

  vt_raster_cnt #(
    .PIX_W (PIX_W)
  ) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .tim_rst  (tim_rst),
    .lcfg     (lcfg),
    .last_pix (last_pix),
    .half_pix (half_pix),
    .pix      (pix),
    .line     (line),
    .field    (field)
  );

  vt_sync_decode #(
    .PIX_W (PIX_W)
  ) i_dec (
    .clk       (clk),
    .rst       (rst),
    .pix_en    (pix_en),
    .tim_rst   (tim_rst),
    .lcfg      (lcfg),
    .half_pix  (half_pix),
    .hs_pix    (hs_pix),
    .act_pix   (act_pix),
    .burst_beg (burst_beg),
    .burst_end (burst_end),
    .pix       (pix),
    .line      (line),
    .field     (field),
    .hs_n      (hs_n),
    .vs_n      (vs_n),
    .blank     (blank),
    .burst     (burst),
    .act_start (act_start),
    .line_num  (line_num),
    .field_num (field_num)
  );

endmodule

// File: rtl/vt_raster_chk.sv
module vt_raster_chk
  import vt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               pix_en,
  input logic               tim_rst,
  input logic               hs_n,
  input logic               vs_n,
  input logic               blank,
  input logic               burst,
  input logic               act_start,
  input logic [LINE_W-1:0]  line_num,
  input logic [FIELD_W-1:0] field_num
);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (pix_en && tim_rst) |=> (hs_n && vs_n && blank && !burst && !act_start &&
                             line_num == '0 && field_num == '0));

  assert_freeze_R13: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(hs_n) && $stable(vs_n) && $stable(blank) && $stable(burst) &&
                 $stable(act_start) && $stable(line_num) && $stable(field_num)));

  assert_act_visible_R10: assert property (@(posedge clk) disable iff (rst)
    act_start |-> (!blank && !burst && hs_n));

  assert_burst_blanked_R11: assert property (@(posedge clk) disable iff (rst)
    burst |-> (blank && hs_n));

  assert_sync_blanked_R5: assert property (@(posedge clk) disable iff (rst)
    !hs_n |-> blank);

  assert_odd_mark_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(hs_n) && $fell(vs_n)) |-> (line_num == LINE_W'(1) && field_num[0]));

  assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
    (line_num <= LINE_W'(PAL_FRAME_LINES) && field_num <= FIELD_W'(PAL_FIELDS)));

endmodule

bind vt_raster_gen vt_raster_chk i_chk (.*);

// File: tb/test_vt_raster_gen.sv
module test_vt_raster_gen;

  localparam int NL = 28;
  localparam int NH = 5;
  localparam int NA = 4;
  localparam int PL = 36;
  localparam int PH = 7;
  localparam int PA = 5;
  localparam int BO = 1;
  localparam int BP = 2;
  localparam int WATCHDOG = 199000;

  logic       clk = 1'b0;
  logic       rst;
  logic       pix_en;
  logic       tim_rst;
  logic [1:0] mode;
  logic       hs_n, vs_n, blank, burst, act_start;
  logic [9:0] line_num;
  logic [3:0] field_num;

  always #2 clk = ~clk;

  vt_raster_gen #(
    .NTSC_LINE_PIX (NL), .NTSC_HS_PIX (NH), .NTSC_ACT_OFS (NA),
    .PAL_LINE_PIX  (PL), .PAL_HS_PIX  (PH), .PAL_ACT_OFS  (PA),
    .BURST_OFS     (BO), .BURST_PIX   (BP)
  ) i_vt_raster_gen (
    .clk (clk), .rst (rst), .pix_en (pix_en), .tim_rst (tim_rst), .mode (mode),
    .hs_n (hs_n), .vs_n (vs_n), .blank (blank), .burst (burst), .act_start (act_start),
    .line_num (line_num), .field_num (field_num)
  );

  int    checks = 0;
  int    fails  = 0;
  int    m_mode, m_p, m_l, m_f;
  string line_tag;
  logic  last_hs, last_vs, last_bl, last_bu, last_ac;
  logic [9:0] last_ln;
  logic [3:0] last_fn;

  function automatic int f_len(int md);  return (md < 2) ? NL : PL; endfunction
  function automatic int f_hs(int md);   return (md < 2) ? NH : PH; endfunction
  function automatic int f_act(int md);  return (md < 2) ? NH + NA : PH + PA; endfunction
  function automatic int f_lines(int md);
    return (md == 0) ? 525 : (md == 1) ? 263 : (md == 2) ? 625 : 313;
  endfunction
  function automatic int f_mid(int md);  return (md < 2) ? 263 : 313; endfunction
  function automatic int f_nf(int md);   return (md == 0) ? 4 : (md == 2) ? 8 : 1; endfunction
  function automatic bit f_il(int md);   return (md == 0) || (md == 2); endfunction

  function automatic bit vb(int md, int l, int p);
    int h = f_len(md) / 2;
    if (md < 2)
      return (l <= 17) || (l >= 261 && l <= 279) || (l >= 523) ||
             (l == 260 && p >= h) || (l == 280 && p < h);
    else
      return (l <= 22) || (l >= 311 && l <= 335) || (l >= 624) ||
             (l == 623 && p >= h) || (l == 23 && p < h);
  endfunction

  function automatic bit ex_blank(int md, int l, int p);
    return vb(md, l, p) || (p < f_act(md));
  endfunction

  function automatic bit ex_vs_low(int md, int l, int p);
    int h = f_len(md) / 2;
    if (md < 2)
      return (l <= 3) ||
             (f_il(md) && ((l == 263 && p >= h) || l == 264 || l == 265 || (l == 266 && p < h)));
    else
      return (l <= 2) || (l == 3 && p < h) ||
             (f_il(md) && ((l == 313 && p >= h) || l == 314 || l == 315));
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (mode %0d line %0d pix %0d)",
               tag, what, act, exp, m_mode, m_l, m_p);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "idle hs_n", hs_n, 1);
    chk(tag, "idle vs_n", vs_n, 1);
    chk(tag, "idle blank", blank, 1);
    chk(tag, "idle burst", burst, 0);
    chk(tag, "idle act_start", act_start, 0);
    chk(tag, "idle line_num", line_num, 0);
    chk(tag, "idle field_num", field_num, 0);
    last_hs = 1'b1;
    last_vs = 1'b1;
  endtask

  task automatic check_pos();
    bit e_bl, e_ac, e_bu, coinc_e, coinc_a;
    int st;
    e_bl = ex_blank(m_mode, m_l, m_p);
    e_ac = !e_bl && (m_p > 0) && ex_blank(m_mode, m_l, m_p - 1);
    st   = f_hs(m_mode) + BO;
    e_bu = !vb(m_mode, m_l, 0) && (m_p >= st) && (m_p < st + BP);
    chk("R5", "hs_n", hs_n, (m_p < f_hs(m_mode)) ? 0 : 1);
    chk("R6", "vs_n", vs_n, ex_vs_low(m_mode, m_l, m_p) ? 0 : 1);
    chk((m_mode < 2) ? "R8" : "R9", "blank", blank, e_bl);
    chk("R10", "act_start", act_start, e_ac);
    chk("R11", "burst", burst, e_bu);
    chk(line_tag, "line_num", line_num, m_l);
    chk(line_tag, "field_num", field_num, m_f);
    coinc_e = (m_p == 0) && (m_l == 1);
    coinc_a = last_hs && last_vs && !hs_n && !vs_n;
    chk("R7", "coincident sync fall", coinc_a, coinc_e);
    last_hs = hs_n; last_vs = vs_n; last_bl = blank; last_bu = burst;
    last_ac = act_start; last_ln = line_num; last_fn = field_num;
  endtask

  task automatic advance();
    m_p++;
    if (m_p == f_len(m_mode)) begin
      m_p = 0;
      m_l++;
      if (m_l > f_lines(m_mode)) m_l = 1;
    end
    if (f_il(m_mode)) begin
      if (m_l == 1 && m_p == 0) m_f = (m_f == f_nf(m_mode)) ? 1 : m_f + 1;
      else if (m_l == f_mid(m_mode) && m_p == f_len(m_mode) / 2) m_f++;
    end
  endtask

  task automatic run(input int n, input int stall_every);
    for (int i = 0; i < n; i++) begin
      if (stall_every > 0 && (i % stall_every) == stall_every - 1) begin
        pix_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R13", "hs_n frozen", hs_n, last_hs);
        chk("R13", "vs_n frozen", vs_n, last_vs);
        chk("R13", "blank frozen", blank, last_bl);
        chk("R13", "burst frozen", burst, last_bu);
        chk("R13", "act_start frozen", act_start, last_ac);
        chk("R13", "line_num frozen", line_num, last_ln);
        chk("R13", "field_num frozen", field_num, last_fn);
        pix_en = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      check_pos();
      advance();
    end
  endtask

  task automatic tim_restart(input int md, input int hold);
    mode    = 2'(md);
    tim_rst = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      chk_idle("R12");
    end
    tim_rst = 1'b0;
    m_mode = md; m_p = 0; m_l = 1; m_f = 1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; pix_en = 1'b1; tim_rst = 1'b0; mode = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1");
    rst = 1'b0;
    // R1: reset default is NTSC although mode input says progressive PAL
    m_mode = 0; m_p = 0; m_l = 1; m_f = 1;
    line_tag = "R1";
    run(40 * NL, 0);
    // R2: a mode change without timing reset is ignored
    mode = 2'b10;
    line_tag = "R2";
    run(10 * NL, 0);
    // R3: interlaced NTSC, full 4-field sequence and wrap, with stalls (R13)
    tim_restart(0, 2);
    line_tag = "R3";
    run(1052 * NL, 16);
    // R3: interlaced PAL, full 8-field sequence and wrap
    tim_restart(2, 2);
    run(2502 * PL, 0);
    // R4: progressive NTSC and PAL, two fields plus a line
    tim_restart(1, 2);
    line_tag = "R4";
    run(527 * NL, 0);
    tim_restart(3, 2);
    run(627 * PL, 0);
    // R12: timing reset in mid-frame; R2: new mode taken during it
    tim_restart(2, 1);
    line_tag = "R3";
    run(50 * PL + 7, 0);
    tim_restart(0, 4);
    line_tag = "R2";
    run(30 * NL, 0);
    summary();
    $finish;
  end

endmodule